// File: doc/BRIEF.md
# Program Counter and Stack Pointer Sequencer

This block holds the instruction address and the stack pointer of a small accumulator machine and works out both for the next instruction. An instruction decoder drives one control pin per kind of control transfer or stack operation. The block chooses the next program counter from among these sources: the current value plus one, the instruction operand, the current value plus a signed operand, or the accumulator. The choice follows a fixed priority when more than one pin is high. Each instruction carries an 8-bit opcode and an operand of up to 32 bits. Decoding that opcode is done outside this block.

The stack lives in data memory and grows toward higher addresses. A push stores the accumulator at the address held in the stack pointer and then moves the pointer up by one. A pop reads from one below the pointer and moves the pointer down. For both, the block drives the address and a read or write strobe in the same cycle. Calls and returns are built in software from the PC-to-accumulator and accumulator-to-PC transfers together with push and pop. The current program counter is always visible on `pc_o`, so the accumulator can capture it for the save-PC operation.

All pins are plain control or status lines: there is no stream traffic, so there is no valid/ready handshake and no back-pressure. `step` marks the cycle in which the presented controls execute. A halt freezes the block until reset.

Top module: `pc_sp_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `pc_o` and `sp_o` are 0, `halted_o` is 0, and both stack strobes are 0.
- R2: In a cycle with `step` low, `pc_o` and `sp_o` keep their values at the next edge, and both stack strobes are 0.
- R3: A step with no jump, halt or load control high (this covers no-op, save-PC, push and pop) makes `pc_o` equal to the old value plus 1, modulo 2^32. During the step, `pc_o` shows the address that the accumulator captures for save-PC.
- R4: A step with `op_jmp` high loads `pc_o` with `operand`.
- R5: A step with `op_jmp_rel` high loads `pc_o` with the old `pc_o` plus `operand`, read as a signed two's-complement offset and wrapping modulo 2^32.
- R6: Each conditional jump pin is paired with one flag (`op_jmp_z` with `flag_z`, `op_jmp_ov` with `flag_ov`, `op_jmp_c` with `flag_c`, `op_jmp_eq` with `flag_eq`). If the paired flag is 1, the next PC is `operand`. If the flag is 0, the PC advances by 1.
- R7: A step with `op_load_pc` high loads `pc_o` with `acc_in`.
- R8: When several controls are high in one step, the priority from highest to lowest is: halt, load-PC, absolute jump, relative jump, any taken conditional jump, advance by 1.
- R9: A push step without halt raises `stack_we_o` for that cycle, with `stack_addr_o` equal to `sp_o`. After the edge, `sp_o` is one higher.
- R10: A pop step without halt raises `stack_re_o` for that cycle, with `stack_addr_o` equal to `sp_o` minus 1. After the edge, `sp_o` equals that address. If push and pop are both high, push wins and `stack_re_o` stays 0.
- R11: A push or pop in the same step as a jump or PC load still updates the stack pointer as in R9 and R10, while the PC follows R4 to R8.
- R12: A step with `op_halt` high keeps `pc_o` and `sp_o`, raises no stack strobe, and sets `halted_o` from the next cycle. From then on, `pc_o` and `sp_o` hold and both strobes stay 0 whatever the inputs, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step | input | 1 | Controls on the other pins execute this cycle |
| op_halt | input | 1 | Halt request |
| op_load_pc | input | 1 | Load PC from accumulator |
| op_jmp | input | 1 | Absolute jump to operand |
| op_jmp_rel | input | 1 | Jump by signed operand offset |
| op_jmp_z | input | 1 | Jump if zero flag set |
| op_jmp_ov | input | 1 | Jump if overflow flag set |
| op_jmp_c | input | 1 | Jump if carry flag set |
| op_jmp_eq | input | 1 | Jump if equal flag set |
| op_push | input | 1 | Push accumulator |
| op_pop | input | 1 | Pop into accumulator |
| flag_z | input | 1 | Zero flag |
| flag_ov | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| flag_eq | input | 1 | Equal flag |
| operand | input | 32 | Instruction operand |
| acc_in | input | 32 | Accumulator value |
| pc_o | output | 32 | Current instruction address, also the save-PC value |
| sp_o | output | 32 | Current stack pointer |
| stack_addr_o | output | 32 | Data memory address for the stack access this cycle |
| stack_we_o | output | 1 | Stack write strobe (push) |
| stack_re_o | output | 1 | Stack read strobe (pop) |
| halted_o | output | 1 | Block is halted |

## Verification
The stack strobes and `stack_addr_o` are combinational from the controls and the current pointer, so they are due in the step cycle itself. The bench samples them 1 ns after driving the inputs at the falling edge. The new `pc_o` and `sp_o` come one register later, as does `halted_o` after a halt step, so the bench checks them at the next falling edge against a model that it advances at the same rising edge. Reset values are read at a falling edge while reset is held and again after it is released.

// File: rtl/pcsp_pkg.sv
package pcsp_pkg;
  // number of flag-qualified jump kinds
  localparam int unsigned NCOND = 4;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_ABS,
    SRC_REL,
    SRC_ACC
  } pc_src_e;

  typedef enum logic [1:0] {
    SP_KEEP,
    SP_UP,
    SP_DOWN
  } sp_op_e;
endpackage

// File: rtl/pcsp_pc_sel.sv
module pcsp_pc_sel
  import pcsp_pkg::*;
#(
  parameter int unsigned NC = NCOND
) (
  input  logic          step,
  input  logic          halted,
  input  logic          op_halt,
  input  logic          op_load_pc,
  input  logic          op_jmp,
  input  logic          op_jmp_rel,
  input  logic [NC-1:0] op_jcc,
  input  logic [NC-1:0] flags,
  output pc_src_e       src,
  output logic          run,
  output logic          halt_now
);
  logic [NC-1:0] hit;

  generate
    for (genvar g = 0; g < NC; g++) begin : g_cond
      assign hit[g] = op_jcc[g] & flags[g];
    end
  endgenerate

  assign halt_now = step & ~halted & op_halt;
  assign run      = step & ~halted & ~op_halt;

  always_comb begin
    if (!run)            src = SRC_HOLD;
    else if (op_load_pc) src = SRC_ACC;
    else if (op_jmp)     src = SRC_ABS;
    else if (op_jmp_rel) src = SRC_REL;
    else if (|hit)       src = SRC_ABS;
    else                 src = SRC_INC;
  end
endmodule

// File: rtl/pcsp_next_pc.sv
module pcsp_next_pc
  import pcsp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] acc,
  input  pc_src_e       src,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] pc_inc;
  logic [AW-1:0] pc_rel;

  // two's-complement add gives signed offset with wrap
  assign pc_inc = pc + ONE;
  assign pc_rel = pc + operand;

  always_comb begin
    unique case (src)
      SRC_INC: nxt = pc_inc;
      SRC_ABS: nxt = operand;
      SRC_REL: nxt = pc_rel;
      SRC_ACC: nxt = acc;
      default: nxt = pc;
    endcase
  end
endmodule

// File: rtl/pcsp_stack.sv
module pcsp_stack
  import pcsp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic          re
);
  localparam logic [AW-1:0] ONE = AW'(1);

  sp_op_e        op;
  logic [AW-1:0] sp_dec;

  assign sp_dec = sp - ONE;

  always_comb begin
    if (!run)      op = SP_KEEP;
    else if (push) op = SP_UP;
    else if (pop)  op = SP_DOWN;
    else           op = SP_KEEP;
  end

  assign we   = (op == SP_UP);
  assign re   = (op == SP_DOWN);
  assign addr = re ? sp_dec : sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
    end else begin
      unique case (op)
        SP_UP:   sp <= sp + ONE;
        SP_DOWN: sp <= sp_dec;
        default: sp <= sp;
      endcase
    end
  end
endmodule

// File: rtl/pc_sp_unit.sv
module pc_sp_unit
  import pcsp_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          op_halt,
  input  logic          op_load_pc,
  input  logic          op_jmp,
  input  logic          op_jmp_rel,
  input  logic          op_jmp_z,
  input  logic          op_jmp_ov,
  input  logic          op_jmp_c,
  input  logic          op_jmp_eq,
  input  logic          op_push,
  input  logic          op_pop,
  input  logic          flag_z,
  input  logic          flag_ov,
  input  logic          flag_c,
  input  logic          flag_eq,
  input  logic [AW-1:0] operand,
  input  logic [AW-1:0] acc_in,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] stack_addr_o,
  output logic          stack_we_o,
  output logic          stack_re_o,
  output logic          halted_o
);
  logic [AW-1:0]    pc_q;
  logic [AW-1:0]    pc_d;
  logic             halted_q;
  logic             run;
  logic             halt_now;
  pc_src_e          src;
  logic [NCOND-1:0] jcc;
  logic [NCOND-1:0] flg;

  assign jcc = {op_jmp_eq, op_jmp_c, op_jmp_ov, op_jmp_z};
  assign flg = {flag_eq, flag_c, flag_ov, flag_z};

  pcsp_pc_sel #(.NC(NCOND)) i_sel (
    .step       (step),
    .halted     (halted_q),
    .op_halt    (op_halt),
    .op_load_pc (op_load_pc),
    .op_jmp     (op_jmp),
    .op_jmp_rel (op_jmp_rel),
    .op_jcc     (jcc),
    .flags      (flg),
    .src        (src),
    .run        (run),
    .halt_now   (halt_now)
  );

  pcsp_next_pc #(.AW(AW)) i_npc (
    .pc      (pc_q),
    .operand (operand),
    .acc     (acc_in),
    .src     (src),
    .nxt     (pc_d)
  );

  pcsp_stack #(.AW(AW)) i_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .push  (op_push),
    .pop   (op_pop),
    .sp    (sp_o),
    .addr  (stack_addr_o),
    .we    (stack_we_o),
    .re    (stack_re_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      pc_q <= pc_d;
      if (halt_now) halted_q <= 1'b1;
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/pc_sp_unit_chk.sv
module pc_sp_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          op_halt,
  input logic          op_load_pc,
  input logic          op_jmp,
  input logic          op_jmp_rel,
  input logic          op_jmp_z,
  input logic          op_jmp_ov,
  input logic          op_jmp_c,
  input logic          op_jmp_eq,
  input logic [AW-1:0] acc_in,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] sp_o,
  input logic [AW-1:0] stack_addr_o,
  input logic          stack_we_o,
  input logic          stack_re_o,
  input logic          halted_o
);
  logic any_xfer;
  assign any_xfer = op_halt | op_load_pc | op_jmp | op_jmp_rel |
                    op_jmp_z | op_jmp_ov | op_jmp_c | op_jmp_eq;

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (pc_o == $past(pc_o)) && (sp_o == $past(sp_o)));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !halted_o && !any_xfer) |=> pc_o == $past(pc_o) + AW'(1));

  assert_load_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !halted_o && !op_halt && op_load_pc) |=> pc_o == $past(acc_in));

  assert_push_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_we_o |-> stack_addr_o == sp_o);

  assert_push_sp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_we_o |=> sp_o == $past(sp_o) + AW'(1));

  assert_pop_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_re_o |=> sp_o == $past(stack_addr_o));

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o && (pc_o == $past(pc_o)) && (sp_o == $past(sp_o)));

  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !stack_we_o && !stack_re_o);
endmodule

bind pc_sp_unit pc_sp_unit_chk #(.AW(AW)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step         (step),
  .op_halt      (op_halt),
  .op_load_pc   (op_load_pc),
  .op_jmp       (op_jmp),
  .op_jmp_rel   (op_jmp_rel),
  .op_jmp_z     (op_jmp_z),
  .op_jmp_ov    (op_jmp_ov),
  .op_jmp_c     (op_jmp_c),
  .op_jmp_eq    (op_jmp_eq),
  .acc_in       (acc_in),
  .pc_o         (pc_o),
  .sp_o         (sp_o),
  .stack_addr_o (stack_addr_o),
  .stack_we_o   (stack_we_o),
  .stack_re_o   (stack_re_o),
  .halted_o     (halted_o)
);

// File: tb/test_pc_sp_unit.sv
`timescale 1ns/1ps
module test_pc_sp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        op_halt = 1'b0, op_load_pc = 1'b0, op_jmp = 1'b0, op_jmp_rel = 1'b0;
  logic        op_jmp_z = 1'b0, op_jmp_ov = 1'b0, op_jmp_c = 1'b0, op_jmp_eq = 1'b0;
  logic        op_push = 1'b0, op_pop = 1'b0;
  logic        flag_z = 1'b0, flag_ov = 1'b0, flag_c = 1'b0, flag_eq = 1'b0;
  logic [31:0] operand = '0, acc_in = '0;
  logic [31:0] pc_o, sp_o, stack_addr_o;
  logic        stack_we_o, stack_re_o, halted_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc, m_sp;
  logic        m_halt;

  always #2.5 clk = ~clk;

  pc_sp_unit i_pc_sp_unit (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  function automatic logic [31:0] exp_pc(input logic [31:0] pc);
    logic taken;
    taken = (op_jmp_z & flag_z) | (op_jmp_ov & flag_ov) | (op_jmp_c & flag_c) | (op_jmp_eq & flag_eq);
    if (!step || m_halt || op_halt) return pc;
    if (op_load_pc) return acc_in;
    if (op_jmp) return operand;
    if (op_jmp_rel) return pc + operand;
    if (taken) return operand;
    return pc + 32'd1;
  endfunction

  task automatic clear_ctl();
    step = 0; op_halt = 0; op_load_pc = 0; op_jmp = 0; op_jmp_rel = 0;
    op_jmp_z = 0; op_jmp_ov = 0; op_jmp_c = 0; op_jmp_eq = 0;
    op_push = 0; op_pop = 0;
  endtask

  task automatic do_reset();
    clear_ctl();
    rst_n = 0;
    @(negedge clk);
    check(pc_o == 0 && sp_o == 0, "R1 reset pc/sp", pc_o | sp_o, 32'd0);
    check(!halted_o && !stack_we_o && !stack_re_o, "R1 reset status",
          {29'd0, halted_o, stack_we_o, stack_re_o}, 32'd0);
    rst_n = 1;
    m_pc = 0; m_sp = 0; m_halt = 0;
    @(negedge clk);
    check(pc_o == 0 && sp_o == 0 && !halted_o, "R1 after release", pc_o | sp_o, 32'd0);
  endtask

  // inputs already driven at a falling edge; runs one cycle
  task automatic run_cycle(input string req);
    logic        run, e_we, e_re;
    logic [31:0] e_addr, n_pc, n_sp;
    logic        n_halt;
    #1;
    run  = step && !m_halt && !op_halt;
    e_we = run && op_push;
    e_re = run && op_pop && !op_push;
    e_addr = e_re ? m_sp - 32'd1 : m_sp;
    check(stack_we_o == e_we && stack_re_o == e_re, {req, " R9/R10 strobes"},
          {30'd0, stack_we_o, stack_re_o}, {30'd0, e_we, e_re});
    if (e_we || e_re)
      check(stack_addr_o == e_addr, {req, " R9/R10 addr"}, stack_addr_o, e_addr);
    n_pc = exp_pc(m_pc);
    n_sp = e_we ? m_sp + 32'd1 : (e_re ? m_sp - 32'd1 : m_sp);
    n_halt = m_halt || (step && op_halt);
    @(negedge clk);
    m_pc = n_pc; m_sp = n_sp; m_halt = n_halt;
    check(pc_o == m_pc, {req, " pc"}, pc_o, m_pc);
    check(sp_o == m_sp, {req, " sp"}, sp_o, m_sp);
    check(halted_o == m_halt, {req, " R12 halted"}, {31'd0, halted_o}, {31'd0, m_halt});
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R3 plain advance, save-PC value visible on pc_o
    clear_ctl(); step = 1;
    run_cycle("R3 advance");
    check(pc_o == 32'd1, "R3 save-PC value", pc_o, 32'd1);
    // R2 step low
    clear_ctl(); op_jmp = 1; operand = 32'h55; op_push = 1;
    run_cycle("R2 idle");
    // R4 absolute
    clear_ctl(); step = 1; op_jmp = 1; operand = 32'h0000_1000;
    run_cycle("R4 jmp");
    // R5 negative relative
    clear_ctl(); step = 1; op_jmp_rel = 1; operand = 32'hFFFF_FFF0;
    run_cycle("R5 rel back");
    // R6 conditional not taken then taken
    clear_ctl(); step = 1; op_jmp_c = 1; flag_c = 0; flag_z = 1; operand = 32'h77;
    run_cycle("R6 not taken");
    clear_ctl(); step = 1; op_jmp_eq = 1; flag_eq = 1; operand = 32'h88;
    run_cycle("R6 taken");
    // R7
    clear_ctl(); step = 1; op_load_pc = 1; acc_in = 32'hDEAD_BEEF;
    run_cycle("R7 load pc");
    // R8 priority load vs jmp
    clear_ctl(); step = 1; op_load_pc = 1; op_jmp = 1; operand = 32'h10; acc_in = 32'h20;
    run_cycle("R8 load over jmp");
    clear_ctl(); step = 1; op_jmp = 1; op_jmp_rel = 1; operand = 32'h30;
    run_cycle("R8 jmp over rel");
    // R9 push, R10 pop, push wins
    clear_ctl(); step = 1; op_push = 1;
    run_cycle("R9 push");
    clear_ctl(); step = 1; op_push = 1; op_pop = 1;
    run_cycle("R10 push wins");
    clear_ctl(); step = 1; op_pop = 1;
    run_cycle("R10 pop");
    // R11 push with jump
    clear_ctl(); step = 1; op_push = 1; op_jmp = 1; operand = 32'h400;
    run_cycle("R11 push+jmp");
    // R12 halt over jump, then frozen
    clear_ctl(); step = 1; op_halt = 1; op_jmp = 1; op_push = 1;
    run_cycle("R12 halt");
    clear_ctl(); step = 1; op_jmp = 1; op_pop = 1; operand = 32'h9;
    run_cycle("R12 frozen");
    do_reset();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      clear_ctl();
      step       = (r[2:0] != 0);
      op_halt    = ($urandom_range(0, 150) == 0);
      op_load_pc = ($urandom_range(0, 9) == 0);
      op_jmp     = ($urandom_range(0, 7) == 0);
      op_jmp_rel = ($urandom_range(0, 7) == 0);
      op_jmp_z   = ($urandom_range(0, 5) == 0);
      op_jmp_ov  = ($urandom_range(0, 5) == 0);
      op_jmp_c   = ($urandom_range(0, 5) == 0);
      op_jmp_eq  = ($urandom_range(0, 5) == 0);
      op_push    = ($urandom_range(0, 3) == 0);
      op_pop     = ($urandom_range(0, 3) == 0);
      {flag_z, flag_ov, flag_c, flag_eq} = r[7:4];
      operand = r[8] ? $urandom : {{24{r[9]}}, r[31:24]};
      acc_in  = $urandom;
      run_cycle("R8 random");
      if (m_halt && r[12:10] == 0) do_reset();
    end
    finish_run();
  end
endmodule